// File: doc/BRIEF.md
# Flash In-System Programming Command Sequencer

This block runs in-system programming commands against an embedded flash array. Software loads an address, a data word and a 7-bit command code into registers, then writes 1 to a trigger bit. In the first cycle after the trigger, the block checks the request. It rejects unknown codes, misaligned addresses, addresses past the end of the array, and program or erase requests aimed at a region whose update enable is clear. A request that passes drives a request/done handshake to the array. A request that fails ends at once with a sticky fail flag.

The array is split into three regions by parameters: an application region from 0 up to `LDR_BASE`, a loader region from `LDR_BASE` up to `CFG_BASE`, and a configuration region from `CFG_BASE` up to `ARR_BYTES`. Writes to the operand registers or to the trigger while a command is in flight are dropped. Such a write is recorded as a conflict, and the fail flag is set with it. An interrupt flag collects completions and failures. It drives the `irq` pin only while the interrupt enable is set.

Register select codes are CTRL=0, ADDR=1, DATA=2, CMD=3, TRIG=4 and STAT=5.

- CTRL fields: bit0 application enable, bit1 loader enable, bit2 configuration enable, bit3 fail flag (write 1 to clear), bit4 interrupt enable.
- STAT fields: bit0 busy, bit1 fail (write 1 to clear), bit2 conflict (write 1 to clear), bit3 interrupt flag (write 1 to clear).
- TRIG: bit0 is go and reads back as busy.

Top module: `isp_flash_seq`

## Requirements
- R1: After reset, every register reads 0, `arr_req` is 0 and `irq` is 0.
- R2: Writing TRIG with bit0=1 while idle makes busy read 1 from the next cycle. Busy, and TRIG bit0 with it, returns to 0 in the cycle after the command completes or fails.
- R3: Only the codes 0x00, 0x04, 0x0B, 0x0C, 0x21, 0x22, 0x23, 0x25, 0x27, 0x2D, 0x40 and 0x61 are accepted. Any other code sets the fail flag one cycle after the trigger and never raises `arr_req`.
- R4: Codes 0x00, 0x21 and 0x27 need address bits [1:0]=0. Codes 0x40 and 0x61 need bits [2:0]=0. Code 0x2D needs bits [10:0]=0. A violation sets the fail flag.
- R5: An address of `ARR_BYTES` or more sets the fail flag. The ID reads 0x04, 0x0B and 0x0C are exempt from this check.
- R6: Program codes (0x21, 0x27, 0x61) and page erase (0x22) fail when aimed at a region whose enable bit in CTRL is 0.
- R7: Bank erase (0x23) and block erase (0x25) fail unless the address lies in the application region and its enable is 1.
- R8: The fail flag stays set until software writes 1 to CTRL bit3 or to STAT bit1. A set in the same cycle wins over the clear.
- R9: A write to ADDR, DATA, CMD or TRIG while busy has no effect on that register. It sets the conflict bit, the fail flag and the interrupt flag.
- R10: The interrupt flag is set on every completion or failure, and it is cleared by writing 1 to STAT bit3. `irq` equals the flag AND CTRL bit4.
- R11: When a read-class command (0x00, 0x40, 0x04, 0x0B, 0x0C) completes, DATA holds `arr_rdata`. During a program command, `arr_wdata` presents DATA.
- R12: `arr_req` rises one cycle after a command passes its checks. It stays high, with `arr_addr`, `arr_op` and `arr_wdata` stable, until the cycle in which `arr_done` is sampled high. `arr_op` is 0 for a read, 1 for a program, 2 for an erase and 3 for a checksum run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wsel | input | 3 | Register selected for the write |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 3 | Register selected for readback |
| reg_rdata | output | 32 | Readback data (combinational) |
| arr_req | output | 1 | Array request, held until done |
| arr_op | output | 2 | Array operation kind |
| arr_addr | output | 32 | Array address |
| arr_wdata | output | 32 | Program data |
| arr_done | input | 1 | Array completion pulse |
| arr_rdata | input | 32 | Array read data, valid with done |
| irq | output | 1 | Interrupt output |

## Verification
Each register write shows in readback one cycle after the clock edge that samples it. A trigger raises busy one cycle later. A rejected command clears busy and sets fail and the interrupt flag on the next edge. For an accepted command, `arr_req` is high on the next edge, and busy, DATA and the interrupt flag update one cycle after `arr_done` is sampled. The bench's behavioural model advances on the same edges. Every readback field, `irq` and `arr_req` are compared against it at each falling edge, half a cycle after the register update. Scenario checks then read the fail and conflict flags once busy has dropped.

// File: rtl/isp_pkg.sv
`timescale 1ns/1ps
package isp_pkg;
  localparam int AW = 32;

  typedef enum logic [2:0] {K_BAD, K_READ, K_ID, K_PROG, K_ERASE, K_BULK, K_CKS} cmd_kind_e;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_AUX = 2'd3} arr_op_e;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_ADDR = 3'd1;
  localparam logic [2:0] SEL_DATA = 3'd2;
  localparam logic [2:0] SEL_CMD  = 3'd3;
  localparam logic [2:0] SEL_TRIG = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;

  function automatic cmd_kind_e kind_of(input logic [6:0] c);
    case (c)
      7'h00, 7'h40:        return K_READ;
      7'h04, 7'h0B, 7'h0C: return K_ID;
      7'h21, 7'h27, 7'h61: return K_PROG;
      7'h22:               return K_ERASE;
      7'h23, 7'h25:        return K_BULK;
      7'h2D:               return K_CKS;
      default:             return K_BAD;
    endcase
  endfunction

  // number of low address bits that must be zero
  function automatic int unsigned zero_bits(input logic [6:0] c);
    case (c)
      7'h00, 7'h21, 7'h27: return 2;
      7'h40, 7'h61:        return 3;
      7'h2D:               return 11;
      default:             return 0;
    endcase
  endfunction

  function automatic logic addr_aligned(input logic [6:0] c, input logic [AW-1:0] a);
    logic [AW-1:0] mask;
    mask = (AW'(1) << zero_bits(c)) - AW'(1);
    return (a & mask) == '0;
  endfunction

  function automatic arr_op_e op_of(input cmd_kind_e k);
    case (k)
      K_PROG:         return OP_PROG;
      K_ERASE, K_BULK: return OP_ERASE;
      K_CKS:          return OP_AUX;
      default:        return OP_READ;
    endcase
  endfunction
endpackage

// File: rtl/isp_checker.sv
`timescale 1ns/1ps
module isp_checker
  import isp_pkg::*;
#(
  parameter int unsigned ARR_BYTES = 32'h4000,
  parameter int unsigned LDR_BASE  = 32'h3000,
  parameter int unsigned CFG_BASE  = 32'h3800
) (
  input  logic [6:0]    cmd,
  input  logic [AW-1:0] addr,
  input  logic          app_en,
  input  logic          ldr_en,
  input  logic          cfg_en,
  output logic          pass,
  output logic          is_load,
  output arr_op_e       op
);
  localparam logic [AW-1:0] LIM_END = AW'(ARR_BYTES);
  localparam logic [AW-1:0] LIM_LDR = AW'(LDR_BASE);
  localparam logic [AW-1:0] LIM_CFG = AW'(CFG_BASE);

  cmd_kind_e kind;
  logic code_ok, align_ok, range_ok, perm_ok;
  logic in_app, in_ldr, in_cfg;

  always_comb begin
    kind     = kind_of(cmd);
    code_ok  = (kind != K_BAD);
    align_ok = addr_aligned(cmd, addr);
    range_ok = (kind == K_ID) || (addr < LIM_END);
    in_app   = addr < LIM_LDR;
    in_ldr   = (addr >= LIM_LDR) && (addr < LIM_CFG);
    in_cfg   = (addr >= LIM_CFG) && (addr < LIM_END);
    case (kind)
      K_PROG, K_ERASE: perm_ok = (in_app & app_en) | (in_ldr & ldr_en) | (in_cfg & cfg_en);
      K_BULK:          perm_ok = in_app & app_en;
      default:         perm_ok = 1'b1;
    endcase
    pass    = code_ok & align_ok & range_ok & perm_ok;
    is_load = (kind == K_READ) || (kind == K_ID);
    op      = op_of(kind);
  end
endmodule

// File: rtl/isp_fsm.sv
`timescale 1ns/1ps
module isp_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pass,
  input  logic is_load,
  input  logic arr_done,
  output logic busy,
  output logic arr_req,
  output logic fail_evt,
  output logic done_evt,
  output logic load_evt
);
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WAIT} st_e;
  st_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else begin
      case (st)
        S_IDLE:  if (start) st <= S_CHECK;
        S_CHECK: st <= pass ? S_WAIT : S_IDLE;
        S_WAIT:  if (arr_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign arr_req  = (st == S_WAIT);
  assign fail_evt = (st == S_CHECK) && !pass;
  assign done_evt = arr_req && arr_done;
  assign load_evt = done_evt && is_load;

  // R3
  no_handshake_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> !arr_req && !busy);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && !arr_done |=> arr_req);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/isp_regfile.sv
`timescale 1ns/1ps
module isp_regfile
  import isp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    wsel,
  input  logic [AW-1:0] wdata,
  input  logic          busy,
  input  logic          fail_evt,
  input  logic          done_evt,
  input  logic          load_evt,
  input  logic [AW-1:0] load_val,
  output logic          start,
  output logic          app_en,
  output logic          ldr_en,
  output logic          cfg_en,
  output logic          int_en,
  output logic          fail_q,
  output logic          conf_q,
  output logic          int_q,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] data_q,
  output logic [6:0]    cmd_q
);
  logic operand_sel, conflict_evt, accept, fail_clr, conf_clr, int_clr;

  assign operand_sel  = (wsel == SEL_ADDR) || (wsel == SEL_DATA) ||
                        (wsel == SEL_CMD)  || (wsel == SEL_TRIG);
  assign conflict_evt = we && busy && operand_sel;
  assign accept       = we && !conflict_evt;
  assign start        = accept && (wsel == SEL_TRIG) && wdata[0];
  assign fail_clr     = accept && (((wsel == SEL_CTRL) && wdata[3]) ||
                                   ((wsel == SEL_STAT) && wdata[1]));
  assign conf_clr     = accept && (wsel == SEL_STAT) && wdata[2];
  assign int_clr      = accept && (wsel == SEL_STAT) && wdata[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {app_en, ldr_en, cfg_en, int_en} <= '0;
      {fail_q, conf_q, int_q}          <= '0;
      addr_q <= '0;
      data_q <= '0;
      cmd_q  <= '0;
    end else begin
      if (accept && wsel == SEL_CTRL) begin
        app_en <= wdata[0];
        ldr_en <= wdata[1];
        cfg_en <= wdata[2];
        int_en <= wdata[4];
      end
      if (accept && wsel == SEL_ADDR) addr_q <= wdata;
      if (accept && wsel == SEL_CMD)  cmd_q  <= wdata[6:0];
      if (load_evt)                       data_q <= load_val;
      else if (accept && wsel == SEL_DATA) data_q <= wdata;
      // set wins over write-1-to-clear
      if (fail_evt || conflict_evt) fail_q <= 1'b1;
      else if (fail_clr)            fail_q <= 1'b0;
      if (conflict_evt)   conf_q <= 1'b1;
      else if (conf_clr)  conf_q <= 1'b0;
      if (fail_evt || conflict_evt || done_evt) int_q <= 1'b1;
      else if (int_clr)                         int_q <= 1'b0;
    end
  end

  // R9
  conflict_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_evt |=> fail_q && conf_q && int_q);
  // R8
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q && !fail_clr |=> fail_q);
  // R10
  done_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> int_q);
  // R9
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_evt |=> $stable(addr_q) && $stable(cmd_q));
endmodule

// File: rtl/isp_flash_seq.sv
`timescale 1ns/1ps
module isp_flash_seq
  import isp_pkg::*;
#(
  parameter int unsigned ARR_BYTES = 32'h4000,
  parameter int unsigned LDR_BASE  = 32'h3000,
  parameter int unsigned CFG_BASE  = 32'h3800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_wsel,
  input  logic [31:0] reg_wdata,
  input  logic [2:0]  reg_rsel,
  output logic [31:0] reg_rdata,
  output logic        arr_req,
  output logic [1:0]  arr_op,
  output logic [31:0] arr_addr,
  output logic [31:0] arr_wdata,
  input  logic        arr_done,
  input  logic [31:0] arr_rdata,
  output logic        irq
);
  logic start, busy, pass, is_load, fail_evt, done_evt, load_evt;
  logic app_en, ldr_en, cfg_en, int_en, fail_q, conf_q, int_q;
  logic [AW-1:0] addr_q, data_q;
  logic [6:0] cmd_q;
  arr_op_e op;

  isp_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wsel(reg_wsel), .wdata(reg_wdata),
    .busy(busy), .fail_evt(fail_evt), .done_evt(done_evt), .load_evt(load_evt),
    .load_val(arr_rdata), .start(start), .app_en(app_en), .ldr_en(ldr_en),
    .cfg_en(cfg_en), .int_en(int_en), .fail_q(fail_q), .conf_q(conf_q),
    .int_q(int_q), .addr_q(addr_q), .data_q(data_q), .cmd_q(cmd_q)
  );

  isp_checker #(.ARR_BYTES(ARR_BYTES), .LDR_BASE(LDR_BASE), .CFG_BASE(CFG_BASE)) u_chk (
    .cmd(cmd_q), .addr(addr_q), .app_en(app_en), .ldr_en(ldr_en), .cfg_en(cfg_en),
    .pass(pass), .is_load(is_load), .op(op)
  );

  isp_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .pass(pass), .is_load(is_load),
    .arr_done(arr_done), .busy(busy), .arr_req(arr_req), .fail_evt(fail_evt),
    .done_evt(done_evt), .load_evt(load_evt)
  );

  assign arr_op    = op;
  assign arr_addr  = addr_q;
  assign arr_wdata = data_q;
  assign irq       = int_q & int_en;

  always_comb begin
    case (reg_rsel)
      SEL_CTRL: reg_rdata = {27'd0, int_en, fail_q, cfg_en, ldr_en, app_en};
      SEL_ADDR: reg_rdata = addr_q;
      SEL_DATA: reg_rdata = data_q;
      SEL_CMD:  reg_rdata = {25'd0, cmd_q};
      SEL_TRIG: reg_rdata = {31'd0, busy};
      SEL_STAT: reg_rdata = {28'd0, int_q, conf_q, fail_q, busy};
      default:  reg_rdata = '0;
    endcase
  end

  // R12
  req_operands_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && !arr_done |=> $stable(arr_addr) && $stable(arr_op) && $stable(arr_wdata));
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> int_en);
endmodule

// File: tb/isp_flash_seq_test.sv
`timescale 1ns/1ps
module isp_flash_seq_test;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_wsel = 0, reg_rsel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic arr_req, irq;
  logic [1:0] arr_op;
  logic [31:0] arr_addr, arr_wdata;
  logic arr_done = 0;
  logic [31:0] arr_rdata = 0;

  int checks = 0, errors = 0, cycles = 0;

  isp_flash_seq uut (.*);

  always #2.5 clk = ~clk;

  // ---- array stand-in: fixed latency, 64-word storage ----
  logic [31:0] mem [64];
  int lat = 0;
  always @(posedge clk) begin
    arr_done <= 1'b0;
    if (arr_req && !arr_done) begin
      if (lat == 3) begin
        lat = 0;
        arr_done <= 1'b1;
        case (arr_op)
          2'd0: arr_rdata <= mem[arr_addr[7:2]] ^ {24'd0, arr_addr[15:8]};
          2'd1: mem[arr_addr[7:2]] = arr_wdata;
          2'd2: mem[arr_addr[7:2]] = 32'hFFFF_FFFF;
          default: ;
        endcase
      end else lat = lat + 1;
    end
  end

  // ---- behavioural reference model ----
  int ph = 0;  // 0 idle, 1 checking, 2 waiting on array
  bit m_app, m_ldr, m_cfg, m_ien, m_fail, m_conf, m_int;
  logic [31:0] m_addr, m_data;
  logic [6:0] m_cmd;

  function automatic bit ref_ok(input logic [6:0] c, input logic [31:0] a, input bit ea, el, ec);
    int z; bit known, id, wr, bulk;
    known = 1; id = 0; wr = 0; bulk = 0; z = 0;
    if (c == 7'h00 || c == 7'h21 || c == 7'h27) z = 4;
    else if (c == 7'h40 || c == 7'h61) z = 8;
    else if (c == 7'h2D) z = 2048;
    if (c == 7'h04 || c == 7'h0B || c == 7'h0C) id = 1;
    else if (c == 7'h21 || c == 7'h27 || c == 7'h61 || c == 7'h22) wr = 1;
    else if (c == 7'h23 || c == 7'h25) bulk = 1;
    else if (!(c == 7'h00 || c == 7'h40 || c == 7'h2D)) known = 0;
    if (!known) return 0;
    if (z != 0 && (a % z) != 0) return 0;
    if (!id && a >= 32'h4000) return 0;
    if (bulk) return (a < 32'h3000) && ea;
    if (wr) begin
      if (a < 32'h3000) return ea;
      if (a < 32'h3800) return el;
      return ec;
    end
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; {m_app, m_ldr, m_cfg, m_ien, m_fail, m_conf, m_int} = '0;
      m_addr = 0; m_data = 0; m_cmd = 0;
    end else begin
      bit was_busy, sf, si, sc;
      was_busy = (ph != 0); sf = 0; si = 0; sc = 0;
      if (ph == 1) begin
        if (ref_ok(m_cmd, m_addr, m_app, m_ldr, m_cfg)) ph = 2;
        else begin ph = 0; sf = 1; si = 1; end
      end else if (ph == 2 && arr_done) begin
        ph = 0; si = 1;
        if (m_cmd inside {7'h00, 7'h40, 7'h04, 7'h0B, 7'h0C}) m_data = arr_rdata;
      end
      if (reg_we) begin
        if (was_busy && reg_wsel inside {[3'd1:3'd4]}) begin sf = 1; si = 1; sc = 1; end
        else case (reg_wsel)
          3'd0: begin m_app = reg_wdata[0]; m_ldr = reg_wdata[1]; m_cfg = reg_wdata[2];
                      m_ien = reg_wdata[4]; if (reg_wdata[3]) m_fail = 0; end
          3'd1: m_addr = reg_wdata;
          3'd2: m_data = reg_wdata;
          3'd3: m_cmd = reg_wdata[6:0];
          3'd4: if (reg_wdata[0]) ph = 1;
          3'd5: begin if (reg_wdata[1]) m_fail = 0; if (reg_wdata[2]) m_conf = 0;
                      if (reg_wdata[3]) m_int = 0; end
          default: ;
        endcase
      end
      if (sf) m_fail = 1;
      if (si) m_int = 1;
      if (sc) m_conf = 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, half a cycle after the update edge
  always @(negedge clk) if (rst_n) begin
    cycles++;
    reg_rsel = 3'd5; #0.4;
    chk("R2 busy", reg_rdata[0], ph != 0);
    chk("R8 fail", reg_rdata[1], m_fail);
    chk("R9 conflict", reg_rdata[2], m_conf);
    chk("R10 intflag", reg_rdata[3], m_int);
    chk("R10 irq", irq, m_int & m_ien);
    chk("R12 req", arr_req, ph == 2);
    reg_rsel = 3'd2; #0.4;
    chk("R11 data", reg_rdata, m_data);
    reg_rsel = 3'd4; #0.4;
    chk("R2 trig mirror", reg_rdata, {31'd0, ph != 0});
  end

  always @(posedge clk) if (cycles > 20000) begin
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    reg_we = 1; reg_wsel = s; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && ph != 0; i++) begin @(posedge clk); #1; end
  endtask

  task automatic look(input string tag, input int bitpos, input bit exp);
    @(negedge clk); #2;
    reg_rsel = 3'd5; #0.1;
    chk(tag, reg_rdata[bitpos], exp);
    @(posedge clk); #1;
  endtask

  task automatic op(input logic [6:0] c, input logic [31:0] a, input logic [31:0] d,
                    input bit exp_fail, input string tag);
    wr(3'd1, a); wr(3'd2, d); wr(3'd3, {25'd0, c}); wr(3'd4, 1);
    wait_idle();
    look(tag, 1, exp_fail);
    wr(3'd5, 32'hE);  // clear fail, conflict, intflag
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    #12 rst_n = 1;
    @(negedge clk); #2;
    for (int s = 0; s < 6; s++) begin
      reg_rsel = 3'(s); #0.05;
      chk("R1 reset reg", reg_rdata, 0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 req", arr_req, 0);
    @(posedge clk); #1;
    wr(3'd0, 32'h11);                                    // app enable, irq enable
    op(7'h21, 32'h100, 32'hA5A5_1234, 0, "R11 program");
    op(7'h00, 32'h100, 32'h0, 0, "R11 read");
    chk("R11 read value", m_data, 32'hA5A5_1235);        // model data is itself compared each cycle
    op(7'h22, 32'h100, 32'h0, 0, "R6 page erase app");
    op(7'h00, 32'h100, 32'h0, 0, "R11 read erased");
    op(7'h30, 32'h100, 32'h0, 1, "R3 invalid code");
    op(7'h7F, 32'h0, 32'h0, 1, "R3 invalid code 7F");
    op(7'h21, 32'h102, 32'h1, 1, "R4 word misaligned");
    op(7'h61, 32'h104, 32'h1, 1, "R4 dword misaligned");
    op(7'h61, 32'h108, 32'h1, 0, "R4 dword aligned");
    op(7'h2D, 32'h400, 32'h0, 1, "R4 checksum misaligned");
    op(7'h2D, 32'h800, 32'h0, 0, "R4 checksum aligned");
    op(7'h00, 32'h4000, 32'h0, 1, "R5 out of range");
    op(7'h0C, 32'h4000, 32'h0, 0, "R5 id read exempt");
    op(7'h21, 32'h3000, 32'h7, 1, "R6 loader locked");
    op(7'h21, 32'h3800, 32'h7, 1, "R6 config locked");
    wr(3'd0, 32'h17);
    op(7'h21, 32'h3000, 32'h7, 0, "R6 loader open");
    op(7'h27, 32'h3804, 32'h9, 0, "R6 config open");
    op(7'h23, 32'h3000, 32'h0, 1, "R7 bank erase outside app");
    op(7'h25, 32'h0, 32'h0, 0, "R7 block erase in app");
    wr(3'd0, 32'h16);
    op(7'h23, 32'h0, 32'h0, 1, "R7 bank erase app locked");
    wr(3'd0, 32'h11);
    // R8: fail sticky, cleared through CTRL bit3
    wr(3'd1, 32'h1); wr(3'd3, 32'h21); wr(3'd4, 1); wait_idle();
    wr(3'd0, 32'h11);
    look("R8 sticky after unrelated write", 1, 1);
    wr(3'd0, 32'h19);
    look("R8 cleared via ctrl", 1, 0);
    // R9: operand write while busy
    wr(3'd1, 32'h10); wr(3'd2, 32'h55); wr(3'd3, 32'h21); wr(3'd4, 1);
    wr(3'd2, 32'hDEAD_BEEF);
    wr(3'd1, 32'h20);
    wait_idle();
    look("R9 conflict set", 2, 1);
    look("R9 fail set", 1, 1);
    reg_rsel = 3'd1; #0.1; chk("R9 addr kept", reg_rdata, 32'h10);
    reg_rsel = 3'd2; #0.1; chk("R9 data kept", reg_rdata, 32'h55);
    wr(3'd5, 32'hE);
    // R10: flag without enable keeps irq low
    wr(3'd0, 32'h01);
    op(7'h00, 32'h10, 32'h0, 0, "R10 op");
    wr(3'd1, 32'h10); wr(3'd3, 32'h00); wr(3'd4, 1); wait_idle();
    look("R10 flag set", 3, 1);
    chk("R10 irq masked", irq, 0);
    wr(3'd0, 32'h11); @(negedge clk); #2;
    chk("R10 irq enabled", irq, 1);
    @(posedge clk); #1;
    wr(3'd5, 32'h8);
    repeat (3) @(posedge clk);
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule